// File: doc/BRIEF.md
# Indexed Super-I/O Configuration Register File

This block holds 256 byte-wide configuration registers that a host reaches through a pair of adjacent ports on an ISA-style I/O bus. The even port is the index port. A write there selects a register number. The odd port is the data port. A write there stores a byte into the selected register. A read from either port returns the selected register.

A per-index protection map decides which registers take data. Most of the space is read-only. Two base-address registers take a write only when the byte equals their single legal value. Otherwise they keep what they hold.

The parent bridge owns an enable bit. While that bit is clear, the port pair does not respond: reads return 0xFF and writes are dropped. Writes commit on the clock edge after the strobe. Reads are combinational from the stored state.

Top module: `sio_index_regfile`

## Requirements
- R1: After reset the index is 0x00. Register 0xE0 holds 0x3C, 0xE2 holds 0x03, 0xE3 holds 0xFC, 0xE6 holds 0xDE, 0xE7 holds 0xFE and 0xE8 holds 0xBE. Every other register holds 0x00.
- R2: A write to the index port (address BASE, default 0x3F0) loads the written byte into the index. A read in the next cycle returns the newly selected register.
- R3: A data-port write (address BASE+1, default 0x3F1) is discarded when the index is in 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R4: A data-port write with index 0xE7 is stored only if the byte is 0xFE. Any other byte leaves the register unchanged.
- R5: A data-port write with index 0xE8 is stored only if the byte is 0xBE. Any other byte leaves the register unchanged.
- R6: A data-port write with the index on an unprotected register (0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8, 0xFC) stores the byte. A read in the next cycle returns it.
- R7: A read at either port of the pair returns the register selected by the current index.
- R8: While `bridge_en` is low, reads return 0xFF. Writes change neither the index nor any register.
- R9: Accesses to addresses outside the pair return 0xFF on read and change nothing on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bridge_en | input | 1 | Port-pair enable from the parent bridge |
| io_addr | input | AW (16) | I/O address |
| io_wr | input | 1 | Single-byte write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data: selected register, or 0xFF when not decoded |

## Verification
Every write, whether to the index or to a register, becomes visible exactly one clock edge after the strobe. Read data follows address, index and enable combinationally in the same cycle.

The bench drives each access on a falling edge and lets one rising edge commit it. On the next falling edge it switches to a data-port read and samples one time unit later. Each check therefore observes the state after exactly one commit. Checks that a write had no effect re-enable the port where needed and read the untouched register back through the data port.

// File: rtl/sio_index_regfile.sv
module sio_index_regfile #(
  parameter int             AW   = 16,
  parameter logic [AW-1:0]  BASE = 16'h03F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bridge_en,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata
);
  localparam int NREG = 256;
  localparam logic [7:0] LEGAL_A = 8'hFE;
  localparam logic [7:0] LEGAL_B = 8'hBE;

  logic [7:0] regs [NREG];
  logic [7:0] idx;
  logic       hit, wr_idx, wr_dat, accept;
  logic [7:0] cur;

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      8'hE0:   rst_val = 8'h3C;
      8'hE2:   rst_val = 8'h03;
      8'hE3:   rst_val = 8'hFC;
      8'hE6:   rst_val = 8'hDE;
      8'hE7:   rst_val = LEGAL_A;
      8'hE8:   rst_val = LEGAL_B;
      default: rst_val = 8'h00;
    endcase
  endfunction

  function automatic logic locked(input logic [7:0] i);
    if (i <= 8'hDF) locked = 1'b1;
    else case (i)
      8'hE4, 8'hE5, 8'hE9, 8'hEA, 8'hEB, 8'hEC, 8'hED,
      8'hF3, 8'hF5, 8'hF7, 8'hF9, 8'hFA, 8'hFB,
      8'hFD, 8'hFE, 8'hFF: locked = 1'b1;
      default:             locked = 1'b0;
    endcase
  endfunction

  assign hit    = bridge_en && (io_addr[AW-1:1] == BASE[AW-1:1]);
  assign wr_idx = hit && io_wr && !io_addr[0];
  assign wr_dat = hit && io_wr &&  io_addr[0];
  assign accept = !locked(idx)
                  && !(idx == 8'hE7 && io_wdata != LEGAL_A)
                  && !(idx == 8'hE8 && io_wdata != LEGAL_B);
  assign cur      = regs[idx];
  assign io_rdata = hit ? cur : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= 8'h00;
      for (int i = 0; i < NREG; i++) regs[i] <= rst_val(i);
    end else if (wr_idx) begin
      idx <= io_wdata;
    end else if (wr_dat && accept) begin
      regs[idx] <= io_wdata;
    end
  end

  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> idx == $past(io_wdata));

  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && locked(idx)) |=> $stable(cur));

  p_legal_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && idx == 8'hE7 && io_wdata != LEGAL_A) |=> $stable(cur));

  p_legal_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && idx == 8'hE8 && io_wdata != LEGAL_B) |=> $stable(cur));

  p_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && !locked(idx) && idx != 8'hE7 && idx != 8'hE8)
      |=> cur == $past(io_wdata));

  p_off_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bridge_en) |=> $stable(idx) && $stable(cur));
endmodule

// File: tb/test_sio_index_regfile.sv
module test_sio_index_regfile;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bridge_en = 0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sio_index_regfile i_sio_index_regfile (
    .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .io_addr(io_addr),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata));

  // {port (0 index, 1 data), byte, expected read at data port, requirement}
  localparam int NV = 24;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 8'hE0, 8'h3C, 4'd1},   // R1
    {1'b1, 8'h55, 8'h55, 4'd6},   // R6
    {1'b0, 8'hE2, 8'h03, 4'd1},   // R1
    {1'b0, 8'hE3, 8'hFC, 4'd1},   // R1
    {1'b0, 8'hE6, 8'hDE, 4'd1},   // R1
    {1'b0, 8'hE7, 8'hFE, 4'd1},   // R1
    {1'b1, 8'h12, 8'hFE, 4'd4},   // R4
    {1'b1, 8'hFE, 8'hFE, 4'd4},   // R4
    {1'b0, 8'hE8, 8'hBE, 4'd1},   // R1
    {1'b1, 8'h00, 8'hBE, 4'd5},   // R5
    {1'b1, 8'hBF, 8'hBE, 4'd5},   // R5
    {1'b0, 8'h10, 8'h00, 4'd2},   // R2
    {1'b1, 8'hAA, 8'h00, 4'd3},   // R3
    {1'b0, 8'hDF, 8'h00, 4'd2},   // R2
    {1'b1, 8'h09, 8'h00, 4'd3},   // R3
    {1'b0, 8'hE4, 8'h00, 4'd2},   // R2
    {1'b1, 8'h77, 8'h00, 4'd3},   // R3
    {1'b0, 8'hFF, 8'h00, 4'd2},   // R2
    {1'b1, 8'h01, 8'h00, 4'd3},   // R3
    {1'b0, 8'hEE, 8'h00, 4'd2},   // R2
    {1'b1, 8'h5A, 8'h5A, 4'd6},   // R6
    {1'b0, 8'hFC, 8'h00, 4'd2},   // R2
    {1'b1, 8'hC3, 8'hC3, 4'd6},   // R6
    {1'b0, 8'hEE, 8'h5A, 4'd2}    // R2
  };

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (io_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, io_rdata, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic rd_at(input logic [15:0] a);
    io_addr = a;
    #1;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1;
    bridge_en = 1;
    rd_at(16'h03F1); check("R1 index reg 00", 8'h00);
    rd_at(16'h03F0); check("R7 read at index port", 8'h00);

    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][20] ? 16'h03F1 : 16'h03F0, VEC[k][19:12]);
      rd_at(16'h03F1);
      n_chk++;
      if (io_rdata !== VEC[k][11:4]) begin
        n_bad++;
        $display("FAIL R%0d vec %0d: got %02h expected %02h",
                 VEC[k][3:0], k, io_rdata, VEC[k][11:4]);
      end
    end

    // R7: index port read returns selected register (EE = 5A)
    rd_at(16'h03F0); check("R7 index port read", 8'h5A);

    // R9: off-pair address
    rd_at(16'h03F2); check("R9 off-pair read", 8'hFF);
    wr(16'h03F2, 8'hE0);
    wr(16'h03EF, 8'h11);
    rd_at(16'h03F1); check("R9 off-pair write ignored", 8'h5A);

    // R8: disabled port pair
    bridge_en = 0;
    rd_at(16'h03F1); check("R8 disabled read", 8'hFF);
    wr(16'h03F0, 8'hE0);
    wr(16'h03F1, 8'h99);
    bridge_en = 1;
    rd_at(16'h03F1); check("R8 index and register unchanged", 8'h5A);

    // R1: reset restores values
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd_at(16'h03F1); check("R1 index back to 00", 8'h00);
    wr(16'h03F0, 8'hEE);
    rd_at(16'h03F1); check("R1 EE back to 00", 8'h00);
    wr(16'h03F0, 8'hFC);
    rd_at(16'h03F1); check("R1 FC back to 00", 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule